// File: doc/BRIEF.md
# Buck Regulator Startup and Fault Sequencer

This block is the digital supervisor of a step-down converter. It takes already-resolved digital flags from the analog front end (combined supply good, enable, soft-start finished, overvoltage, undervoltage, an overcurrent sample and over-temperature). From these it decides when the power stage may switch and when the gates must float. It also decides when the soft-start capacitor is discharged or made to follow the feedback node, and when the open-drain power-good line is pulled low.

The sequence runs off, then soft start, then regulation. The three faults are handled differently:

- An overcurrent sample gives a one-cycle restart that empties the soft-start node. The fourth such event since the last off state latches the block off.
- A filtered overvoltage latches the block off at once.
- Over-temperature floats the gates only while it lasts.

Both latched states are left only by dropping supply good or enable. The voltage-monitor flags pass through stability filters of a parameterised length before they act.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is held, and on leaving it, run=0, gate_hiz=1, ss_discharge=0, ss_track=1 and pg_pull_low=1.
- R2: With supply_ok=1 and enable_in=1, the block leaves the off state at the next clock and enters soft start (run=1, gate_hiz=0, ss_track=0). If either of the two is 0 at a clock edge, it is back in the off state after that edge (run=0, gate_hiz=1, ss_track=1).
- R3: pg_pull_low is 0 only in regulation. Regulation is reached at the first clock after ss_done=1 in soft start. Power-good also needs supply_ok and enable_in high, filtered undervoltage and overvoltage low, and ot_flag low. In soft start pg_pull_low stays 1.
- R4: A filtered monitor flag takes a new raw value only after that value has been sampled on FILT_LEN consecutive clock edges. A raw pulse shorter than FILT_LEN clocks has no effect on any output.
- R5: Filtered undervoltage drives pg_pull_low to 1 and leaves run, gate_hiz and ss_discharge untouched. Power-good returns once it clears.
- R6: Filtered overvoltage pulls power-good low at once, and at the next clock the block enters a latched-off state (run=0, gate_hiz=1). The state holds after ov_raw clears, until supply_ok or enable_in is seen low.
- R7: oc_sample=1 in soft start or regulation, other than the event that reaches the limit, gives exactly one cycle with ss_discharge=1, run=0 and gate_hiz=1. After that cycle comes soft start with run=1 and pg_pull_low=1 until ss_done is seen again.
- R8: The OC_LIMIT-th overcurrent event (default 4) since the last off state enters the latched-off state directly, with no discharge cycle. The state holds until supply_ok or enable_in is seen low.
- R9: While ot_flag=1, run=0, gate_hiz=1 and pg_pull_low=1 in the same cycle. When it clears, switching and power-good resume without a new soft start.
- R10: The overcurrent event count clears whenever the block passes through the off state. OC_LIMIT-1 further events after that do not latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Both supply monitors in range (hysteresis applied outside) |
| enable_in | input | 1 | Enable request, already thresholded |
| ss_done | input | 1 | Soft-start node has reached its completion level |
| ov_raw | input | 1 | Unfiltered overvoltage comparator output |
| uv_raw | input | 1 | Unfiltered undervoltage comparator output |
| oc_sample | input | 1 | Overcurrent detected in this switching cycle's sample |
| ot_flag | input | 1 | Over-temperature flag with hysteresis applied outside |
| run | output | 1 | Power stage may switch |
| gate_hiz | output | 1 | Both gate drivers forced to high impedance |
| ss_discharge | output | 1 | Discharge the soft-start capacitor to zero |
| ss_track | output | 1 | Hold the soft-start node at the feedback level |
| pg_pull_low | output | 1 | Power-good open-drain pull-down active |

## Verification
The assertions assume that every input is synchronous to clk and settled between edges. They also assume that oc_sample is a one-cycle pulse per detected event and that ss_done falls again once a discharge has started. The stimulus holds to this by driving all inputs on the falling edge only. It keeps overcurrent to single-cycle pulses and lowers ss_done together with each overcurrent pulse. The random phase keeps every undervoltage burst shorter than the filter length and draws over-temperature freely, so the expected outputs follow from the over-temperature flag alone.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the regulator sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        SEQ_OFF     = 3'd0,
        SEQ_SOFT    = 3'd1,
        SEQ_REG     = 3'd2,
        SEQ_RESTART = 3'd3,
        SEQ_LATCH   = 3'd4
    } seq_state_t;
endpackage

// File: rtl/pwr_flag_filter.sv
// Stability filter: the output takes a new raw value only after that value
// has been sampled on STABLE_LEN consecutive clock edges.
// Assumes: raw is synchronous to clk; STABLE_LEN >= 1.
module pwr_flag_filter #(
    parameter int STABLE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(STABLE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_LEN - 1);

    logic [CW-1:0] run_len;

    // Count consecutive disagreeing samples; flip once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            filt    <= 1'b0;
        end else if (raw == filt) begin
            run_len <= '0;
        end else if (run_len == LAST) begin
            run_len <= '0;
            filt    <= raw;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    // R4: the output only ever moves to the value the raw flag held.
    assert_filter_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> ($past(raw) == filt));
endmodule

// File: rtl/pwr_oc_counter.sv
// Counts overcurrent events since the last clear and flags when the next
// event will be the one that reaches the limit.
// Assumes: inc is a one-cycle pulse per event; OC_LIMIT >= 1.
module pwr_oc_counter #(
    parameter int OC_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic next_is_last
);
    localparam int CW = $clog2(OC_LIMIT + 1);
    localparam logic [CW-1:0] MAXV = CW'(OC_LIMIT);
    localparam logic [CW-1:0] PRE  = CW'(OC_LIMIT - 1);

    logic [CW-1:0] events;

    // Clear takes priority; otherwise count events, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            events <= '0;
        end else if (inc && events != MAXV) begin
            events <= events + 1'b1;
        end
    end

    // Flag for the sequencer: the coming event is the final allowed one.
    always_comb next_is_last = (events >= PRE);

    // R10: a clear request empties the count at the next edge.
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (events == '0));
endmodule

// File: rtl/pwr_seq_fsm.sv
// Sequencing state machine: off, soft start, regulation, one-cycle
// overcurrent restart and latched fault. Drives the stage controls and
// power-good from the state and the filtered monitor flags.
// Assumes: en_ok, oc_sample, ss_done and ot_flag are synchronous to clk.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_ok,
    input  logic ss_done,
    input  logic ov_f,
    input  logic uv_f,
    input  logic oc_sample,
    input  logic ot_flag,
    input  logic oc_last,
    output logic oc_inc,
    output logic oc_clear,
    output logic run,
    output logic gate_hiz,
    output logic ss_discharge,
    output logic ss_track,
    output logic pg_pull_low
);
    seq_state_t state, state_nx;
    logic       active;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_OFF;
        else        state <= state_nx;
    end

    // Next state: disable first, then overvoltage, overcurrent, completion.
    always_comb begin
        state_nx = state;
        if (!en_ok) begin
            state_nx = SEQ_OFF;
        end else begin
            unique case (state)
                SEQ_OFF:     state_nx = SEQ_SOFT;
                SEQ_SOFT, SEQ_REG: begin
                    if (ov_f)              state_nx = SEQ_LATCH;
                    else if (oc_sample)    state_nx = oc_last ? SEQ_LATCH : SEQ_RESTART;
                    else if (ss_done)      state_nx = SEQ_REG;
                end
                SEQ_RESTART: state_nx = ov_f ? SEQ_LATCH : SEQ_SOFT;
                SEQ_LATCH:   state_nx = SEQ_LATCH;
                default:     state_nx = SEQ_OFF;
            endcase
        end
    end

    // Counter handshake: count events while switching, clear while off.
    always_comb begin
        active   = (state == SEQ_SOFT) || (state == SEQ_REG);
        oc_inc   = active && en_ok && !ov_f && oc_sample;
        oc_clear = (state == SEQ_OFF);
    end

    // Stage controls and power-good; over-temperature overlays the state.
    always_comb begin
        run          = active && !ot_flag;
        gate_hiz     = !run;
        ss_discharge = (state == SEQ_RESTART);
        ss_track     = (state == SEQ_OFF);
        pg_pull_low  = !((state == SEQ_REG) && en_ok && !uv_f && !ov_f && !ot_flag);
    end

    // R2: a disable seen at an edge always lands in the off state.
    assert_disable_to_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ok |=> (state == SEQ_OFF));
    // R6, R8: the latched state holds while enabled.
    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_LATCH) && en_ok |=> (state == SEQ_LATCH));
    // R7: a discharge cycle lasts one clock and is followed by soft start.
    assert_restart_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_discharge && en_ok && !ov_f |=> (state == SEQ_SOFT) && !ss_discharge);
    // R1: the off state never drives the stage.
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ss_track |-> gate_hiz && !run && pg_pull_low);
endmodule

// File: rtl/pwr_seq_ctrl.sv
// Top of the regulator startup and fault sequencer. Filters the two
// voltage-monitor flags, counts overcurrent events and runs the sequencer.
// Assumes: all inputs synchronous to clk; FILT_LEN >= 1, OC_LIMIT >= 1.
module pwr_seq_ctrl #(
    parameter int FILT_LEN = 4,
    parameter int OC_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic enable_in,
    input  logic ss_done,
    input  logic ov_raw,
    input  logic uv_raw,
    input  logic oc_sample,
    input  logic ot_flag,
    output logic run,
    output logic gate_hiz,
    output logic ss_discharge,
    output logic ss_track,
    output logic pg_pull_low
);
    localparam int NMON = 2;   // index 0: undervoltage, index 1: overvoltage

    logic [NMON-1:0] mon_raw, mon_filt;
    logic            en_ok, oc_last, oc_inc, oc_clear;

    // Enable-delay condition: supplies in range and enable requested.
    always_comb begin
        en_ok   = supply_ok && enable_in;
        mon_raw = {ov_raw, uv_raw};
    end

    // One stability filter per voltage-monitor flag.
    for (genvar g = 0; g < NMON; g++) begin : g_mon
        pwr_flag_filter #(.STABLE_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (mon_raw[g]),
            .filt (mon_filt[g])
        );
    end

    pwr_oc_counter #(.OC_LIMIT(OC_LIMIT)) u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (oc_clear),
        .inc         (oc_inc),
        .next_is_last(oc_last)
    );

    pwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_ok       (en_ok),
        .ss_done     (ss_done),
        .ov_f        (mon_filt[1]),
        .uv_f        (mon_filt[0]),
        .oc_sample   (oc_sample),
        .ot_flag     (ot_flag),
        .oc_last     (oc_last),
        .oc_inc      (oc_inc),
        .oc_clear    (oc_clear),
        .run         (run),
        .gate_hiz    (gate_hiz),
        .ss_discharge(ss_discharge),
        .ss_track    (ss_track),
        .pg_pull_low (pg_pull_low)
    );

    // R3, R5: power-good released only with both filtered flags low and gates driven.
    assert_pg_needs_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_pull_low |-> (mon_filt == '0) && !gate_hiz);
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 4;
    localparam int OCL  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 0, enable_in = 0, ss_done = 0;
    logic ov_raw = 0, uv_raw = 0, oc_sample = 0, ot_flag = 0;
    logic run, gate_hiz, ss_discharge, ss_track, pg_pull_low;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_ctrl #(.FILT_LEN(FILT), .OC_LIMIT(OCL)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable_in(enable_in),
        .ss_done(ss_done), .ov_raw(ov_raw), .uv_raw(uv_raw), .oc_sample(oc_sample),
        .ot_flag(ot_flag), .run(run), .gate_hiz(gate_hiz), .ss_discharge(ss_discharge),
        .ss_track(ss_track), .pg_pull_low(pg_pull_low)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // Expected stage outputs in regulation, from the over-temperature flag (R9).
    function automatic logic exp_run_reg(input logic ot);
        return !ot;
    endfunction
    function automatic logic exp_pg_low_reg(input logic ot);
        return ot;
    endfunction

    task automatic check_stage(input string req, input logic r, input logic hz,
                               input logic dis, input logic trk, input logic pgl);
        chk({req, " run"}, run, r);
        chk({req, " gate_hiz"}, gate_hiz, hz);
        chk({req, " ss_discharge"}, ss_discharge, dis);
        chk({req, " ss_track"}, ss_track, trk);
        chk({req, " pg_pull_low"}, pg_pull_low, pgl);
    endtask

    // From off (enabled) or restart: soft start, then regulation.
    task automatic go_reg();
        ss_done = 0;
        tick();
        chk("R3 soft start keeps pg low", pg_pull_low, 1'b1);
        ss_done = 1;
        tick();
        chk("R3 regulation releases pg", pg_pull_low, 1'b0);
    endtask

    // One overcurrent pulse that is expected to restart (R7).
    task automatic oc_restart(input string req);
        oc_sample = 1; ss_done = 0;
        tick();
        oc_sample = 0;
        check_stage({req, " discharge cycle"}, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        tick();
        check_stage({req, " back in soft start"}, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        ss_done = 1;
        tick();
        chk({req, " regulation again"}, pg_pull_low, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240613));
        // R1: reset state
        repeat (3) tick();
        check_stage("R1 in reset", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        rst_n = 1;
        tick();
        check_stage("R1 after reset, disabled", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

        // R2: only enable without supply keeps off
        enable_in = 1;
        tick();
        chk("R2 enable without supply stays off", ss_track, 1'b1);
        supply_ok = 1;
        tick();
        check_stage("R2 soft start entered", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        ss_done = 1;
        tick();
        chk("R3 power-good after ss_done", pg_pull_low, 1'b0);

        // R4: undervoltage glitch shorter than the filter
        uv_raw = 1;
        for (int i = 0; i < FILT - 1; i++) begin
            tick();
            chk("R4 short uv pulse ignored", pg_pull_low, 1'b0);
        end
        uv_raw = 0;
        tick();
        chk("R4 short uv pulse ignored after end", pg_pull_low, 1'b0);

        // R5: held undervoltage only holds power-good low
        uv_raw = 1;
        for (int i = 0; i < FILT - 1; i++) tick();
        chk("R4 uv not yet through filter", pg_pull_low, 1'b0);
        tick();
        check_stage("R5 uv filtered", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        uv_raw = 0;
        repeat (FILT) tick();
        chk("R5 pg back after uv clears", pg_pull_low, 1'b0);

        // R9: over-temperature acts in the same cycle and recovers
        ot_flag = 1;
        #1;
        check_stage("R9 ot active", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R9 ot still floating gates", gate_hiz, 1'b1);
        ot_flag = 0;
        #1;
        check_stage("R9 ot cleared, no restart", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tick();

        // R7: three restarting overcurrent events
        for (int k = 0; k < OCL - 1; k++) oc_restart("R7 oc restart");

        // R10: drop enable, count clears
        enable_in = 0;
        tick();
        check_stage("R2 enable dropped to off", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        enable_in = 1;
        tick();
        chk("R2 re-enabled soft start", run, 1'b1);
        ss_done = 1;
        tick();
        for (int k = 0; k < OCL - 1; k++) oc_restart("R10 count cleared, no latch");

        // R8: the limit-th event latches off without discharge
        oc_sample = 1; ss_done = 0;
        tick();
        oc_sample = 0;
        check_stage("R8 latched by oc limit", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        ss_done = 1;
        repeat (5) tick();
        check_stage("R8 latch holds", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);

        // Toggle supply to leave the latch
        supply_ok = 0;
        tick();
        chk("R8 supply drop exits latch", ss_track, 1'b1);
        supply_ok = 1;
        tick();
        chk("R8 restart after toggle", run, 1'b1);
        go_reg();

        // R6: overvoltage latch
        ov_raw = 1;
        for (int i = 0; i < FILT - 1; i++) tick();
        chk("R6 ov not yet through filter", pg_pull_low, 1'b0);
        tick();
        chk("R6 ov pulls pg low at once", pg_pull_low, 1'b1);
        chk("R6 gates still driven this cycle", run, 1'b1);
        tick();
        check_stage("R6 latched off", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        ov_raw = 0;
        repeat (FILT + 4) tick();
        check_stage("R6 latch survives ov clear", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        enable_in = 0;
        tick();
        chk("R6 enable drop exits latch", ss_track, 1'b1);
        enable_in = 1;
        tick();
        go_reg();

        // Random phase: uv bursts below filter length, random ot (R4, R9)
        for (int it = 0; it < 60; it++) begin
            int blen;
            int gap;
            blen = 1 + int'($urandom % (FILT - 1));
            gap  = 1 + int'($urandom % 3);
            for (int c = 0; c < blen + gap; c++) begin
                uv_raw  = (c < blen);
                ot_flag = (($urandom % 4) == 0);
                tick();
                chk("R9 random run", run, exp_run_reg(ot_flag));
                chk("R4 random pg", pg_pull_low, exp_pg_low_reg(ot_flag));
            end
        end
        uv_raw = 0; ot_flag = 0;
        tick();
        chk("R4 random phase left regulation intact", pg_pull_low, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule